// File: doc/BRIEF.md
# External Event Priority Arbiter

This block sits beside a processor core's sequencer and decides which external event the core takes at each instruction boundary. Six request sources compete: a core reset request, a cache flush request, a system-management interrupt, a non-maskable interrupt, a maskable interrupt and a stop-clock request. Whenever the core signals a boundary, the block grants at most one of them. The grant appears one clock later as a one-hot vector together with a one-cycle valid pulse.

Beside the fixed priority, the arbiter keeps the nesting state the core needs. A granted NMI blocks further NMIs until the core reports an interrupt return. One NMI that arrives during the handler is kept and is delivered after that return. A granted SMI blocks further SMIs until the core reports a resume from system-management mode. The block also owns the maskable-interrupt enable flag. The core loads this flag through a strobe, and the block clears it when an NMI is taken.

Top module: `evt_arbiter`

## Requirements
- R1: A grant is issued only for a cycle in which `bnd` is high. `gnt_vec` and `gnt_vld` show that decision on the clock edge after the boundary cycle. `gnt_vld` is high for that single cycle, and `gnt_vec` is one-hot when `gnt_vld` is high and all zero otherwise.
- R2: When several requests are eligible at the same boundary, the granted bit is the lowest-numbered one in this fixed order: bit 0 reset, bit 1 flush, bit 2 SMI, bit 3 NMI, bit 4 INTR, bit 5 stop-clock.
- R3: After an NMI grant, no further NMI is granted until `iret` has been seen. The block reset or a reset request also ends this blocking.
- R4: A rising edge of `nmi_req` while an NMI is being serviced sets one pending bit, and later edges merge into it. The pending NMI is granted at the first boundary after the cycle that carries `iret`. Only one NMI is delivered for all the merged edges.
- R5: `ie_flag` takes `ie_value` on a cycle with `ie_load`. It is cleared by an NMI grant, and an NMI grant wins over a load in the same cycle.
- R6: After an SMI grant, no further SMI is granted until `rsm` has been seen. SMI rising edges that arrive while the SMI is active are dropped and are not kept.
- R7: A stop-clock request is granted while an NMI handler or an SMI handler is active, provided no higher request is eligible.
- R8: INTR is level-sensitive and is eligible only while `ie_flag` is 1. If the flag is loaded back to 1 inside an NMI handler, a pending INTR is granted at a later boundary.
- R9: A cycle with `rst_req` high clears the pending latches, the NMI and SMI active flags and `ie_flag` on the next edge. A boundary with `rst_req` high grants bit 0.
- R10: A flush grant leaves the NMI and SMI nesting state and the pending latches unchanged.
- R11: NMI and SMI are captured on their rising edge. An edge that arrives in a boundary cycle can be granted at that same boundary. A level that stays high does not raise a new request.
- R12: While `rst_n` is low, `gnt_vec`, `gnt_vld` and `ie_flag` are 0, and all pending and nesting state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| bnd | input | 1 | Instruction-boundary strobe |
| rst_req | input | 1 | Core reset request (level) |
| flush_req | input | 1 | Cache flush request (level) |
| smi_req | input | 1 | System-management interrupt request (edge-captured) |
| nmi_req | input | 1 | Non-maskable interrupt request (edge-captured) |
| intr_req | input | 1 | Maskable interrupt request (level) |
| stpclk_req | input | 1 | Stop-clock request (level) |
| iret | input | 1 | Interrupt-return executed strobe |
| rsm | input | 1 | Resume-from-SMM executed strobe |
| ie_load | input | 1 | Load strobe for the interrupt-enable flag |
| ie_value | input | 1 | Value loaded into the interrupt-enable flag |
| gnt_vec | output | 6 | One-hot grant, bit order as in R2 |
| gnt_vld | output | 1 | One-cycle grant-valid pulse |
| ie_flag | output | 1 | Current interrupt-enable flag |

## Verification
A wrong NMI nesting bit shows up as an NMI grant that comes one handler too early or never comes. The first boundary after the next edge or `iret` exposes it. A pending latch that is lost or duplicated shows as a missing or extra NMI grant at the first boundary after the return. A dropped SMI edge that was wrongly kept shows the same way after `rsm`. A wrong enable flag shows on `ie_flag` one edge after the NMI grant or the load. It also shows on the grant of a waiting INTR at the next boundary. A priority error shows directly as the wrong one-hot bit, one clock after the boundary where several requests meet.

// File: rtl/evt_arb_pkg.sv
package evt_arb_pkg;

  localparam int EVT_N = 6;

  // Grant bit positions; the order is the service priority.
  localparam int EV_RST  = 0;
  localparam int EV_FLSH = 1;
  localparam int EV_SMI  = 2;
  localparam int EV_NMI  = 3;
  localparam int EV_INTR = 4;
  localparam int EV_STPC = 5;

  // Next value of an edge-captured pending latch.
  function automatic logic pend_next(input logic cur, input logic clr,
                                     input logic take, input logic edge_seen,
                                     input logic active, input logic hold_busy);
    if (clr || take)                          pend_next = 1'b0;
    else if (edge_seen && (hold_busy || !active)) pend_next = 1'b1;
    else                                      pend_next = cur;
  endfunction

  // Next value of a handler-active (nesting) flag.
  function automatic logic active_next(input logic cur, input logic clr,
                                       input logic take, input logic leave);
    if (clr)        active_next = 1'b0;
    else if (take)  active_next = 1'b1;
    else if (leave) active_next = 1'b0;
    else            active_next = cur;
  endfunction

endpackage

// File: rtl/evt_nest_track.sv
module evt_nest_track
  import evt_arb_pkg::*;
#(
  parameter bit HOLD_BUSY = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic req,
  input  logic take,
  input  logic leave,
  output logic eligible,
  output logic active,
  output logic pending
);

  logic req_prev;
  logic rise;

  assign rise     = req & ~req_prev;
  assign eligible = (pending | rise) & ~active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_prev <= 1'b0;
      pending  <= 1'b0;
      active   <= 1'b0;
    end else begin
      req_prev <= req;
      pending  <= pend_next(pending, clr, take, rise, active, HOLD_BUSY);
      active   <= active_next(active, clr, take, leave);
    end
  end

  // R3
  no_take_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !active);

  // R9
  clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!active && !pending));

  // R3
  busy_until_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !leave && !clr) |=> active);

endmodule

// File: rtl/evt_prio_pick.sv
module evt_prio_pick #(
  parameter int N = 6
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  logic [N-1:0] above;

  assign above[0] = 1'b0;
  assign gnt[0]   = req[0];

  for (genvar i = 1; i < N; i++) begin : g_chain
    assign above[i] = above[i-1] | req[i-1];
    assign gnt[i]   = req[i] & ~above[i];
  end

  // R2
  always_comb begin
    pick_onehot_chk: assert ($onehot0(gnt));
  end

endmodule

// File: rtl/evt_arbiter.sv
module evt_arbiter
  import evt_arb_pkg::*;
#(
  parameter int GNT_W = EVT_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bnd,
  input  logic             rst_req,
  input  logic             flush_req,
  input  logic             smi_req,
  input  logic             nmi_req,
  input  logic             intr_req,
  input  logic             stpclk_req,
  input  logic             iret,
  input  logic             rsm,
  input  logic             ie_load,
  input  logic             ie_value,
  output logic [GNT_W-1:0] gnt_vec,
  output logic             gnt_vld
  ,output logic            ie_flag
);

  logic [GNT_W-1:0] cand;
  logic [GNT_W-1:0] pick;
  logic [GNT_W-1:0] take;
  logic             smi_elig, smi_busy, smi_pend;
  logic             nmi_elig, nmi_busy, nmi_pend;
  logic             nmi_taken;
  logic             ie_q;
  logic [GNT_W-1:0] gnt_q;
  logic             vld_q;

  evt_nest_track #(.HOLD_BUSY(1'b0)) u_smi (
    .clk(clk), .rst_n(rst_n), .clr(rst_req), .req(smi_req),
    .take(take[EV_SMI]), .leave(rsm),
    .eligible(smi_elig), .active(smi_busy), .pending(smi_pend)
  );

  evt_nest_track #(.HOLD_BUSY(1'b1)) u_nmi (
    .clk(clk), .rst_n(rst_n), .clr(rst_req), .req(nmi_req),
    .take(take[EV_NMI]), .leave(iret),
    .eligible(nmi_elig), .active(nmi_busy), .pending(nmi_pend)
  );

  always_comb begin
    cand          = '0;
    cand[EV_RST]  = rst_req;
    cand[EV_FLSH] = flush_req;
    cand[EV_SMI]  = smi_elig;
    cand[EV_NMI]  = nmi_elig;
    cand[EV_INTR] = intr_req & ie_q;
    cand[EV_STPC] = stpclk_req;
  end

  evt_prio_pick #(.N(GNT_W)) u_pick (
    .req(cand),
    .gnt(pick)
  );

  assign take      = bnd ? pick : '0;
  assign nmi_taken = take[EV_NMI];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      gnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (rst_req || nmi_taken) ie_q <= 1'b0;
      else if (ie_load)         ie_q <= ie_value;
      gnt_q <= take;
      vld_q <= |take;
    end
  end

  assign gnt_vec = gnt_q;
  assign gnt_vld = vld_q;
  assign ie_flag = ie_q;

  // R1
  grant_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld == (|gnt_vec)) && $onehot0(gnt_vec));

  // R1
  grant_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> $past(bnd));

  // R2
  intr_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vec[EV_INTR] |-> $past(!rst_req && !flush_req && !smi_elig && !nmi_elig));

  // R5
  nmi_masks_intr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vec[EV_NMI] |-> !ie_flag);

  // R8
  intr_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vec[EV_INTR] |-> $past(ie_q));

  // R10
  flush_keeps_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take[EV_FLSH] && !iret && !rsm) |=> ($stable(nmi_busy) && $stable(smi_busy)));

  // R6
  smi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_busy && !smi_pend) |=> !smi_pend);

endmodule

// File: tb/test_evt_arbiter.sv
module test_evt_arbiter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bnd = 0, rst_req = 0, flush_req = 0, smi_req = 0, nmi_req = 0;
  logic       intr_req = 0, stpclk_req = 0, iret = 0, rsm = 0, ie_load = 0, ie_value = 0;
  logic [5:0] gnt_vec;
  logic       gnt_vld;
  logic       ie_flag;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  evt_arbiter i_evt_arbiter (
    .clk(clk), .rst_n(rst_n), .bnd(bnd), .rst_req(rst_req), .flush_req(flush_req),
    .smi_req(smi_req), .nmi_req(nmi_req), .intr_req(intr_req), .stpclk_req(stpclk_req),
    .iret(iret), .rsm(rsm), .ie_load(ie_load), .ie_value(ie_value),
    .gnt_vec(gnt_vec), .gnt_vld(gnt_vld), .ie_flag(ie_flag)
  );

  // Row: req id[22:19], inputs {rst,flush,smi,nmi,intr,stp,bnd,iret,rsm,ld,val}[18:8],
  // expected gnt_vld[7], gnt_vec[6:1] (bit5..bit0), ie_flag[0].
  localparam logic [22:0] TBL [31] = '{
    {4'd1,  11'b00000010000, 1'b0, 6'b000000, 1'b0}, // R1 empty boundary
    {4'd5,  11'b00000000011, 1'b0, 6'b000000, 1'b1}, // R5 load ie
    {4'd1,  11'b00001100000, 1'b0, 6'b000000, 1'b1}, // R1 no boundary, no grant
    {4'd8,  11'b00001110000, 1'b1, 6'b010000, 1'b1}, // R8 intr over stop-clock
    {4'd2,  11'b11111110000, 1'b1, 6'b000001, 1'b0}, // R2 all six, reset wins
    {4'd2,  11'b01111110000, 1'b1, 6'b000010, 1'b0}, // R2 flush next
    {4'd8,  11'b00001110000, 1'b1, 6'b100000, 1'b0}, // R8 intr masked
    {4'd11, 11'b00111110000, 1'b1, 6'b000100, 1'b0}, // R11 both edges, SMI first
    {4'd11, 11'b00000010000, 1'b1, 6'b001000, 1'b0}, // R11 NMI from latch
    {4'd5,  11'b00000000011, 1'b0, 6'b000000, 1'b1}, // R5 reload inside handler
    {4'd3,  11'b00011010000, 1'b1, 6'b010000, 1'b1}, // R3 nested NMI held, intr granted
    {4'd1,  11'b00000000000, 1'b0, 6'b000000, 1'b1}, // R1 idle
    {4'd4,  11'b00010000000, 1'b0, 6'b000000, 1'b1}, // R4 second edge merges
    {4'd3,  11'b00000010000, 1'b0, 6'b000000, 1'b1}, // R3 still blocked
    {4'd4,  11'b00000011000, 1'b0, 6'b000000, 1'b1}, // R4 iret cycle, no grant yet
    {4'd4,  11'b00000010000, 1'b1, 6'b001000, 1'b0}, // R4 held NMI delivered
    {4'd3,  11'b00000001000, 1'b0, 6'b000000, 1'b0}, // R3 iret
    {4'd4,  11'b00000010000, 1'b0, 6'b000000, 1'b0}, // R4 only one delivered
    {4'd7,  11'b00100110000, 1'b1, 6'b100000, 1'b0}, // R7 stop-clock inside SMI
    {4'd6,  11'b00000010100, 1'b0, 6'b000000, 1'b0}, // R6 rsm
    {4'd6,  11'b00000010000, 1'b0, 6'b000000, 1'b0}, // R6 busy edge was dropped
    {4'd6,  11'b00100010000, 1'b1, 6'b000100, 1'b0}, // R6 fresh SMI granted
    {4'd11, 11'b00010110000, 1'b1, 6'b001000, 1'b0}, // R11 same-cycle NMI edge
    {4'd7,  11'b00000110000, 1'b1, 6'b100000, 1'b0}, // R7 stop-clock inside NMI
    {4'd9,  11'b10000000000, 1'b0, 6'b000000, 1'b0}, // R9 reset request off-boundary
    {4'd9,  11'b00110010000, 1'b1, 6'b000100, 1'b0}, // R9 SMI free again
    {4'd9,  11'b00010010000, 1'b1, 6'b001000, 1'b0}, // R9 NMI free again
    {4'd10, 11'b01000010000, 1'b1, 6'b000010, 1'b0}, // R10 flush in NMI handler
    {4'd10, 11'b00010010000, 1'b0, 6'b000000, 1'b0}, // R10 NMI still blocked
    {4'd10, 11'b00000001000, 1'b0, 6'b000000, 1'b0}, // R10 iret
    {4'd10, 11'b00000010000, 1'b1, 6'b001000, 1'b0}  // R10 held NMI kept by flush
  };

  task automatic check(input int rq, input logic v, input logic [5:0] g, input logic ie);
    n_run++;
    if (gnt_vld !== v || gnt_vec !== g || ie_flag !== ie) begin
      n_fail++;
      $display("FAIL R%0d: vld=%b gnt=%b ie=%b expected vld=%b gnt=%b ie=%b",
               rq, gnt_vld, gnt_vec, ie_flag, v, g, ie);
    end
  endtask

  task automatic drive(input logic [10:0] x);
    {rst_req, flush_req, smi_req, nmi_req, intr_req, stpclk_req,
     bnd, iret, rsm, ie_load, ie_value} = x;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    n_run++;
    n_fail++;
    $display("FAIL R1: watchdog expired, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(12, 1'b0, 6'b0, 1'b0); // R12 reset state
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 31; k++) begin
      drive(TBL[k][18:8]);
      @(posedge clk);
      @(negedge clk);
      check(int'(TBL[k][22:19]), TBL[k][7], TBL[k][6:1], TBL[k][0]);
    end
    // R12: a mid-run block reset clears a held NMI and the nesting state
    drive(11'b00000000011);
    @(negedge clk);
    drive(11'b00010000000); // NMI handler active from last row: edge is held
    @(negedge clk);
    drive(11'b00000000000);
    rst_n = 1'b0;
    @(negedge clk);
    check(12, 1'b0, 6'b0, 1'b0); // R12
    @(negedge clk);
    rst_n = 1'b1;
    drive(11'b00000010000);
    @(posedge clk);
    @(negedge clk);
    check(12, 1'b0, 6'b0, 1'b0); // R12 held NMI gone
    drive(11'b00010010000);
    @(posedge clk);
    @(negedge clk);
    check(12, 1'b1, 6'b001000, 1'b0); // R12 nesting cleared
    drive(11'b00000000000);
    @(posedge clk);
    @(negedge clk);
    check(1, 1'b0, 6'b0, 1'b0); // R1 pulse lasts one cycle
    finish_run();
  end

endmodule